// File: doc/BRIEF.md
# CAN Receive Acceptance Filter Bank

This block decides whether an identifier word taken off the CAN bus should be kept by the receive path. It holds a bank of four filters. Each filter has a compare mask, a reference identifier and its own enable bit. When a received identifier is strobed in, the block compares it against every enabled filter. One cycle later it presents a registered keep or drop decision. The receive FIFO and the frame parser sit outside this block. They use the decision to store or discard the frame.

Software reaches the bank through a single write port with a two-bit operation code. The four operations set enable bits, clear enable bits, load a filter's mask and load a filter's reference identifier. The mask and identifier of a filter can only be changed while that filter is disabled and while no comparison is in flight. A refused write is reported by a one-cycle pulse and leaves every register as it was. With every filter disabled the bank passes all traffic.

Top module: `can_accept_filter_bank`

## Requirements
- R1: After a synchronous active-low reset: all enable bits are 0, every mask and identifier register is 0, and `filt_busy`, `dec_valid` and `wr_refused` are 0.
- R2: An enable-set write (`cfg_op` = 0) ORs `cfg_data[3:0]` into the enable bits (bit i enables filter i). Enable bits not named in the data keep their value. The result is visible on `filt_en` the cycle after the write edge.
- R3: An enable-clear write (`cfg_op` = 1) clears the enable bits named in `cfg_data[3:0]` and leaves all other enable bits unchanged.
- R4: When the enable snapshot taken at the strobe edge is all zero, the decision is accept, for any identifier.
- R5: Filter i passes an identifier W when (W AND mask_i) equals (id_i AND mask_i). The decision is accept if at least one enabled filter passes W, otherwise drop. A mask write uses `cfg_op` = 2 and an identifier write uses `cfg_op` = 3. Both target the filter numbered by `cfg_sel`.
- R6: A mask or identifier write to a filter whose enable bit is set is refused. The stored value is unchanged, and `wr_refused` is high for the one cycle after the write edge. Accepted writes and enable writes never raise `wr_refused`.
- R7: A mask or identifier write presented while `filt_busy` is high is refused, with the same effects as in R6.
- R8: A strobe sampled at edge k drives `filt_busy` high for the cycle after edge k. The decision then appears with `dec_valid` high for the cycle after edge k+1. Back-to-back strobes are allowed.
- R9: The decision uses the enable bits as they were at the strobe edge. An enable write on that same edge does not affect that decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_op | input | 2 | 0 set enables, 1 clear enables, 2 load mask, 3 load identifier |
| cfg_sel | input | 2 | Target filter for mask and identifier loads |
| cfg_data | input | 32 | Write data (enable bits in [3:0]) |
| rx_stb | input | 1 | Received identifier valid |
| rx_word | input | 32 | Received identifier word |
| filt_en | output | 4 | Current enable bits |
| filt_busy | output | 1 | Comparison in flight; mask and identifier loads refused |
| wr_refused | output | 1 | Previous write was refused |
| dec_valid | output | 1 | Decision valid |
| dec_accept | output | 1 | 1 keep the frame, 0 drop it |

## Verification
The bench goes after several corner cases. The first is an enable write that names some filters. A design that wrote the enable register outright instead of merging into it would silently drop the unnamed filters. A mask load sent to an enabled filter, and one sent in the busy cycle, must both be refused. A design that let either through would change the match result of a later frame, and the bench observes that at the decision output. An enable change on the strobe edge itself checks that the decision uses the snapshot and not the new state. The all-disabled case and the mask-of-zero case catch a design that drops traffic where it should pass everything.

// File: rtl/can_afb_pkg.sv
// Package: shared constants and the write operation encoding for the
// acceptance filter bank. Assumes a two-bit operation field.
package can_afb_pkg;

    localparam int AFB_NUM_FILT = 4;
    localparam int AFB_ID_W     = 32;

    typedef enum logic [1:0] {
        OP_EN_SET  = 2'd0,
        OP_EN_CLR  = 2'd1,
        OP_LD_MASK = 2'd2,
        OP_LD_ID   = 2'd3
    } afb_op_e;

endpackage

// File: rtl/can_afb_regs.sv
// Module: filter register file. Holds the enable bits plus a mask and a
// reference identifier per filter, and applies the write rules.
// Assumes: cfg_data[NUM_FILT-1:0] carries enable bits; busy comes from the
// comparison pipeline; synchronous active-low reset.
module can_afb_regs
    import can_afb_pkg::*;
#(
    parameter int NUM_FILT = AFB_NUM_FILT,
    parameter int ID_W     = AFB_ID_W,
    parameter int SEL_W    = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [1:0]                     cfg_op,
    input  logic [SEL_W-1:0]               cfg_sel,
    input  logic [ID_W-1:0]                cfg_data,
    input  logic                           busy,
    output logic [NUM_FILT-1:0]            en_o,
    output logic [NUM_FILT-1:0][ID_W-1:0]  mask_o,
    output logic [NUM_FILT-1:0][ID_W-1:0]  id_o,
    output logic                           refused_o
);

    logic [NUM_FILT-1:0] en_q;
    logic [NUM_FILT-1:0] ld_ok;
    logic                is_load;
    logic                refuse_d;
    logic                refused_q;

    // Classify the write operation.
    assign is_load = cfg_we && ((cfg_op == OP_LD_MASK) || (cfg_op == OP_LD_ID));

    // Per-filter load permission and storage.
    for (genvar gi = 0; gi < NUM_FILT; gi++) begin : g_filt
        assign ld_ok[gi] = is_load && (32'(cfg_sel) == gi) && !busy && !en_q[gi];

        // Mask register of one filter: loads only when allowed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_o[gi] <= '0;
            end else if (ld_ok[gi] && (cfg_op == OP_LD_MASK)) begin
                mask_o[gi] <= cfg_data;
            end
        end

        // Reference identifier of one filter: loads only when allowed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                id_o[gi] <= '0;
            end else if (ld_ok[gi] && (cfg_op == OP_LD_ID)) begin
                id_o[gi] <= cfg_data;
            end
        end
    end

    // A load that no filter took is refused.
    assign refuse_d = is_load && (ld_ok == '0);

    // Enable bits merge set and clear writes into the current state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (cfg_we && (cfg_op == OP_EN_SET)) begin
            en_q <= en_q | cfg_data[NUM_FILT-1:0];
        end else if (cfg_we && (cfg_op == OP_EN_CLR)) begin
            en_q <= en_q & ~cfg_data[NUM_FILT-1:0];
        end
    end

    // One-cycle refusal report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            refused_q <= 1'b0;
        end else begin
            refused_q <= refuse_d;
        end
    end

    assign en_o      = en_q;
    assign refused_o = refused_q;

endmodule

// File: rtl/can_afb_match.sv
// Module: combinational comparator bank. Reports, per filter, whether the
// masked identifier equals the masked reference, and folds the enabled
// results into one accept bit. Assumes an enable vector of zero means
// accept-all.
module can_afb_match #(
    parameter int NUM_FILT = 4,
    parameter int ID_W     = 32
) (
    input  logic [ID_W-1:0]                word_i,
    input  logic [NUM_FILT-1:0]            en_i,
    input  logic [NUM_FILT-1:0][ID_W-1:0]  mask_i,
    input  logic [NUM_FILT-1:0][ID_W-1:0]  id_i,
    output logic                           accept_o
);

    logic [NUM_FILT-1:0] pass;

    for (genvar gi = 0; gi < NUM_FILT; gi++) begin : g_cmp
        assign pass[gi] = (((word_i ^ id_i[gi]) & mask_i[gi]) == '0);
    end

    // Accept when no filter is enabled or any enabled one passes.
    always_comb begin
        accept_o = (en_i == '0) || ((pass & en_i) != '0);
    end

endmodule

// File: rtl/can_afb_pipe.sv
// Module: two-stage decision pipeline. Stage one captures the identifier
// and the enable snapshot on a strobe and drives busy; stage two registers
// the decision. Assumes register contents can not change under an enabled
// filter while stage one is occupied.
module can_afb_pipe #(
    parameter int NUM_FILT = 4,
    parameter int ID_W     = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           stb_i,
    input  logic [ID_W-1:0]                word_i,
    input  logic [NUM_FILT-1:0]            en_i,
    input  logic [NUM_FILT-1:0][ID_W-1:0]  mask_i,
    input  logic [NUM_FILT-1:0][ID_W-1:0]  id_i,
    output logic                           busy_o,
    output logic                           valid_o,
    output logic                           accept_o,
    output logic [NUM_FILT-1:0]            snap_o
);

    logic                s1_vld;
    logic [ID_W-1:0]     s1_word;
    logic [NUM_FILT-1:0] s1_en;
    logic                acc_d;

    // Stage one: capture identifier and enable snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld  <= 1'b0;
            s1_word <= '0;
            s1_en   <= '0;
        end else begin
            s1_vld <= stb_i;
            if (stb_i) begin
                s1_word <= word_i;
                s1_en   <= en_i;
            end
        end
    end

    can_afb_match #(
        .NUM_FILT (NUM_FILT),
        .ID_W     (ID_W)
    ) u_match (
        .word_i   (s1_word),
        .en_i     (s1_en),
        .mask_i   (mask_i),
        .id_i     (id_i),
        .accept_o (acc_d)
    );

    // Stage two: register the decision and the snapshot it used.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o  <= 1'b0;
            accept_o <= 1'b0;
            snap_o   <= '0;
        end else begin
            valid_o <= s1_vld;
            if (s1_vld) begin
                accept_o <= acc_d;
                snap_o   <= s1_en;
            end
        end
    end

    assign busy_o = s1_vld;

endmodule

// File: rtl/can_accept_filter_bank.sv
// Module: top of the receive acceptance filter bank. Joins the register
// file and the decision pipeline. Assumes one identifier strobe per cycle
// at most and a synchronous active-low reset.
module can_accept_filter_bank
    import can_afb_pkg::*;
#(
    parameter int NUM_FILT = AFB_NUM_FILT,
    parameter int ID_W     = AFB_ID_W,
    localparam int SEL_W   = (NUM_FILT > 1) ? $clog2(NUM_FILT) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_op,
    input  logic [SEL_W-1:0]     cfg_sel,
    input  logic [ID_W-1:0]      cfg_data,
    input  logic                 rx_stb,
    input  logic [ID_W-1:0]      rx_word,
    output logic [NUM_FILT-1:0]  filt_en,
    output logic                 filt_busy,
    output logic                 wr_refused,
    output logic                 dec_valid,
    output logic                 dec_accept
);

    logic [NUM_FILT-1:0][ID_W-1:0] mask_w;
    logic [NUM_FILT-1:0][ID_W-1:0] id_w;
    logic [NUM_FILT-1:0]           en_w;
    logic [NUM_FILT-1:0]           dec_snap;
    logic                          busy_w;

    can_afb_regs #(
        .NUM_FILT (NUM_FILT),
        .ID_W     (ID_W),
        .SEL_W    (SEL_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_op    (cfg_op),
        .cfg_sel   (cfg_sel),
        .cfg_data  (cfg_data),
        .busy      (busy_w),
        .en_o      (en_w),
        .mask_o    (mask_w),
        .id_o      (id_w),
        .refused_o (wr_refused)
    );

    can_afb_pipe #(
        .NUM_FILT (NUM_FILT),
        .ID_W     (ID_W)
    ) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb_i    (rx_stb),
        .word_i   (rx_word),
        .en_i     (en_w),
        .mask_i   (mask_w),
        .id_i     (id_w),
        .busy_o   (busy_w),
        .valid_o  (dec_valid),
        .accept_o (dec_accept),
        .snap_o   (dec_snap)
    );

    assign filt_en   = en_w;
    assign filt_busy = busy_w;

endmodule

// File: rtl/can_afb_chk.sv
// Module: protocol checker for the filter bank, attached by bind.
module can_afb_chk #(
    parameter int NUM_FILT = 4,
    parameter int SEL_W    = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_we,
    input logic [1:0]          cfg_op,
    input logic [SEL_W-1:0]    cfg_sel,
    input logic                rx_stb,
    input logic [NUM_FILT-1:0] filt_en,
    input logic                filt_busy,
    input logic                wr_refused,
    input logic                dec_valid,
    input logic                dec_accept,
    input logic [NUM_FILT-1:0] dec_snap
);

    logic is_load;
    assign is_load = cfg_we && cfg_op[1];

    AST_BUSY_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stb |=> filt_busy); // R8
    AST_VALID_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        filt_busy |=> dec_valid); // R8
    AST_ALL_OFF_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && (dec_snap == '0)) |-> dec_accept); // R4
    AST_EN_HOLDS_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(filt_en)); // R2
    AST_SET_KEEPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_op == 2'd0) |=> ((filt_en & $past(filt_en)) == $past(filt_en))); // R2
    AST_CLR_ADDS_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_op == 2'd1) |=> ((filt_en & ~$past(filt_en)) == '0)); // R3
    AST_LOAD_ENABLED_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (is_load && filt_en[cfg_sel]) |=> wr_refused); // R6
    AST_LOAD_BUSY_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (is_load && filt_busy) |=> wr_refused); // R7
    AST_REFUSE_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_refused |-> $past(is_load)); // R6

endmodule

bind can_accept_filter_bank can_afb_chk #(
    .NUM_FILT (NUM_FILT),
    .SEL_W    (SEL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_op     (cfg_op),
    .cfg_sel    (cfg_sel),
    .rx_stb     (rx_stb),
    .filt_en    (filt_en),
    .filt_busy  (filt_busy),
    .wr_refused (wr_refused),
    .dec_valid  (dec_valid),
    .dec_accept (dec_accept),
    .dec_snap   (dec_snap)
);

// File: tb/can_accept_filter_bank_test.sv
module can_accept_filter_bank_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_op = 2'd0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_data = '0;
    logic        rx_stb = 1'b0;
    logic [31:0] rx_word = '0;
    logic [3:0]  filt_en;
    logic        filt_busy;
    logic        wr_refused;
    logic        dec_valid;
    logic        dec_accept;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [3:0]  m_en = '0;
    logic [31:0] m_mask [4];
    logic [31:0] m_id [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    can_accept_filter_bank uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_op     (cfg_op),
        .cfg_sel    (cfg_sel),
        .cfg_data   (cfg_data),
        .rx_stb     (rx_stb),
        .rx_word    (rx_word),
        .filt_en    (filt_en),
        .filt_busy  (filt_busy),
        .wr_refused (wr_refused),
        .dec_valid  (dec_valid),
        .dec_accept (dec_accept)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic exp_accept(input logic [31:0] w, input logic [3:0] en);
        if (en == 4'd0) return 1'b1;
        for (int i = 0; i < 4; i++)
            if (en[i] && (((w ^ m_id[i]) & m_mask[i]) == 32'd0)) return 1'b1;
        return 1'b0;
    endfunction

    // Apply a write to the model; returns expected refusal (not busy).
    function automatic logic model_write(input logic [1:0] op, input logic [1:0] sel,
                                         input logic [31:0] d);
        case (op)
            2'd0: begin m_en = m_en | d[3:0]; return 1'b0; end
            2'd1: begin m_en = m_en & ~d[3:0]; return 1'b0; end
            default: begin
                if (m_en[sel]) return 1'b1;
                if (op == 2'd2) m_mask[sel] = d; else m_id[sel] = d;
                return 1'b0;
            end
        endcase
    endfunction

    task automatic wr(input string req, input logic [1:0] op, input logic [1:0] sel,
                      input logic [31:0] d);
        logic er;
        @(negedge clk);
        cfg_we = 1'b1; cfg_op = op; cfg_sel = sel; cfg_data = d;
        er = model_write(op, sel, d);
        @(negedge clk);
        cfg_we = 1'b0;
        check({req, " refused"}, {31'd0, wr_refused}, {31'd0, er});
        check({req, " enables"}, {28'd0, filt_en}, {28'd0, m_en});
    endtask

    task automatic strobe(input string req, input logic [31:0] w);
        logic e;
        e = exp_accept(w, m_en);
        @(negedge clk);
        rx_stb = 1'b1; rx_word = w;
        @(negedge clk);
        rx_stb = 1'b0;
        check("R8 busy after strobe", {31'd0, filt_busy}, 32'd1);
        check("R8 no early decision", {31'd0, dec_valid}, 32'd0);
        @(negedge clk);
        check("R8 decision valid", {31'd0, dec_valid}, 32'd1);
        check("R8 busy released", {31'd0, filt_busy}, 32'd0);
        check(req, {31'd0, dec_accept}, {31'd0, e});
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin m_mask[i] = '0; m_id[i] = '0; end
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 enables", {28'd0, filt_en}, 32'd0);
        check("R1 busy", {31'd0, filt_busy}, 32'd0);
        check("R1 valid", {31'd0, dec_valid}, 32'd0);
        check("R1 refused", {31'd0, wr_refused}, 32'd0);
        rst_n = 1'b1;

        // R4 accept-all with nothing enabled, including reset masks of zero
        strobe("R4 all disabled", 32'hDEAD_BEEF);
        wr("R5 load mask0", 2'd2, 2'd0, 32'hFFFF_0000);
        wr("R5 load id0", 2'd3, 2'd0, 32'h1234_0000);
        wr("R5 load mask2", 2'd2, 2'd2, 32'hFFFF_FFFF);
        wr("R5 load id2", 2'd3, 2'd2, 32'hAAAA_5555);
        strobe("R4 still all disabled", 32'h0000_0001);
        wr("R2 set f0", 2'd0, 2'd0, 32'h0000_0001);
        wr("R2 set f2 keeps f0", 2'd0, 2'd0, 32'hFFFF_FFF4);
        strobe("R5 match f0", 32'h1234_ABCD);
        strobe("R5 no match", 32'h1235_0000);
        strobe("R5 match f2", 32'hAAAA_5555);
        // R6 load to enabled filter refused; value unchanged
        wr("R6 mask0 while enabled", 2'd2, 2'd0, 32'h0000_0000);
        wr("R6 id0 while enabled", 2'd3, 2'd0, 32'h9999_0000);
        strobe("R6 mask0 kept", 32'h9999_0000);
        strobe("R6 id0 kept", 32'h1234_0001);
        wr("R3 clear f0 keeps f2", 2'd1, 2'd0, 32'h0000_0001);
        strobe("R3 f0 off", 32'h1234_0000);

        // R7 load in the busy cycle is refused
        begin
            logic e;
            e = exp_accept(32'h0000_0005, m_en);
            @(negedge clk);
            rx_stb = 1'b1; rx_word = 32'h0000_0005;
            @(negedge clk);
            rx_stb = 1'b0;
            check("R7 busy seen", {31'd0, filt_busy}, 32'd1);
            cfg_we = 1'b1; cfg_op = 2'd2; cfg_sel = 2'd1; cfg_data = 32'hFFFF_FFFF;
            @(negedge clk);
            cfg_we = 1'b0;
            check("R7 refused while busy", {31'd0, wr_refused}, 32'd1);
            check("R5 decision next to refused load", {31'd0, dec_accept}, {31'd0, e});
        end
        wr("R2 set f1", 2'd0, 2'd0, 32'h0000_0002);
        strobe("R7 mask1 still zero", 32'h0000_0005);
        wr("R3 clear f1", 2'd1, 2'd0, 32'h0000_0002);

        // R9 enable change on the strobe edge does not affect that decision
        begin
            logic e;
            e = exp_accept(32'h1234_0000, m_en);
            @(negedge clk);
            rx_stb = 1'b1; rx_word = 32'h1234_0000;
            cfg_we = 1'b1; cfg_op = 2'd0; cfg_data = 32'h0000_0001;
            void'(model_write(2'd0, 2'd0, 32'h0000_0001));
            @(negedge clk);
            rx_stb = 1'b0; cfg_we = 1'b0;
            check("R9 enable applied", {28'd0, filt_en}, {28'd0, m_en});
            @(negedge clk);
            check("R9 snapshot decision", {31'd0, dec_accept}, {31'd0, e});
        end
        wr("R3 clear all", 2'd1, 2'd0, 32'h0000_000F);
        strobe("R4 all cleared", 32'h0BAD_F00D);

        // Constrained random phase
        void'($urandom(32'd4242));
        for (int n = 0; n < 400; n++) begin
            int r;
            r = $urandom % 10;
            if (r < 4) begin
                logic [1:0] op;
                logic [31:0] d;
                int pick;
                op = 2'($urandom);
                pick = $urandom % 4;
                d = (op == 2'd2) ? ((pick == 0) ? 32'hFFFF_FFFF : (pick == 1) ? 32'hFFFF_0000 :
                                    (pick == 2) ? 32'h0000_00FF : $urandom)
                                 : $urandom;
                wr(op == 2'd0 ? "R2 random set" : op == 2'd1 ? "R3 random clear" :
                   "R6 random load", op, 2'($urandom), d);
            end else begin
                logic [31:0] w;
                int j;
                j = $urandom % 4;
                w = ($urandom % 2 == 0) ? (m_id[j] ^ ($urandom & ~m_mask[j])) : $urandom;
                strobe("R5 random decision", w);
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule